// File: doc/BRIEF.md
# Single-Precision Round and Pack Unit

This block is the last step of a single-precision arithmetic datapath. An upstream unit hands it an unrounded value: a sign, a signed 16-bit exponent, and a 32-bit significand whose binary point sits between bits 30 and 29. That leaves seven guard bits below the fraction. The exponent is one less than the true biased exponent, because the leading one of the significand is added into the exponent field when the result is packed. The block rounds the value in one of four directions. It saturates overflow, handles results too small for the normal range, and packs a 32-bit IEEE single-precision word. It also reports overflow, underflow, inexact and a rounded-up indication.

Per-exception mask inputs change the result in two ways. An unmasked underflow keeps the value normal by adding 192 to the exponent. A masked underflow denormalizes the significand with a sticky right shift. A flush control replaces tiny denormalized results with a signed zero. Tininess is decided before rounding.

Values arrive on a valid/ready stream and leave through one registered valid/ready stage. The input may be accepted whenever the output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output word and flags hold still and `in_ready` is low. An accepted value appears on the outputs on the next clock edge.

Top module: `sp_round_pack`

## Requirements
- R1: The rounding mode input is encoded as 0 = nearest-even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero. Nearest-even adds half a unit (0x40) to the seven guard bits. A directed mode adds 0x7F when it rounds away from zero for the given sign and adds nothing otherwise. The output word has the sign in bit 31, the exponent in bits 30:23 and the fraction in bits 22:0.
- R2: In nearest-even mode, when the guard bits equal exactly 0x40, the least significant bit of the rounded significand is cleared.
- R3: Overflow occurs when the input exponent is above 0xFD, or equals 0xFD and significand plus increment reaches 2^31. The overflow flag is then raised. Inexact is raised if the guard bits are nonzero or overflow is masked. Rounded-up is raised with inexact when the increment is nonzero. The result is infinity when the increment is nonzero, and the largest finite value of that sign when it is zero.
- R4: Outside the overflow and flush cases, inexact is raised exactly when the guard bits (after any denormalizing shift) are nonzero. Rounded-up is raised when the rounded significand, scaled back by 2^7, exceeds the significand being rounded.
- R5: A negative exponent is tiny when it is below -1, or when significand plus increment stays below 2^31. An exponent of -1 whose rounding reaches 2^31 is not tiny.
- R6: A tiny value with underflow unmasked raises underflow and has 192 added to its exponent before any shift.
- R7: If the exponent is still negative, the significand is shifted right by the exponent's magnitude, with every lost bit ORed into bit 0, and the exponent becomes 0. A shift of 32 or more leaves just the sticky bit. With flush disabled, a tiny value raises underflow here only if the new guard bits are nonzero.
- R8: With flush enabled, a tiny value that reaches the shift returns a zero of the input sign and raises underflow and inexact, without rounded-up.
- R9: A rounded significand of zero forces the exponent field to zero. A carry out of the rounded significand propagates into the exponent field.
- R10: The output register follows the valid/ready rules above. A result appears one cycle after acceptance and is held unchanged while stalled.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Unrounded value present |
| in_ready | output | 1 | Unit can take a value this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 16 | Signed exponent, one below the true biased exponent |
| in_sig | input | 32 | Significand, point between bits 30 and 29, bit 31 zero |
| rnd_mode | input | 2 | Rounding direction (R1 encoding) |
| ovf_masked | input | 1 | Overflow exception masked |
| unf_masked | input | 1 | Underflow exception masked |
| flush_en | input | 1 | Flush tiny denormalized results to zero |
| out_valid | output | 1 | Packed result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Packed single-precision result |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |
| out_up | output | 1 | Magnitude was rounded up |

## Verification
The word and all four flags come from one combinational path and are due together, on the first rising edge after the edge that accepts the value. The bench drives each value on a falling edge with `out_ready` high and drops `in_valid` on the next falling edge, where it compares the result against hand-derived words and flags. For the stall case, `out_ready` is held low for several cycles. The outputs and `in_ready` are resampled on each falling edge in between, then the register is drained.

// File: rtl/sp_round_pack_pkg.sv
package sp_round_pack_pkg;
  localparam int SIG_W    = 32;
  localparam int GRD_W    = 7;
  localparam int EXP_W    = 16;
  localparam int EF_W     = 8;
  localparam int FR_W     = SIG_W - 1 - EF_W;
  localparam int EXP_MAX  = (1 << EF_W) - 1;
  localparam int OVF_EXP  = EXP_MAX - 2;
  localparam int BIAS_ADJ = 192;
  localparam int RSIG_W   = SIG_W - GRD_W;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
    logic up;
  } flags_t;
endpackage

// File: rtl/sp_incsel.sv
module sp_incsel
  import sp_round_pack_pkg::*;
#(
  parameter int G_W = GRD_W
) (
  input  logic [1:0]     mode,
  input  logic           sign,
  output logic [G_W-1:0] inc,
  output logic           near
);
  localparam logic [G_W-1:0] HALF = G_W'(1) << (G_W - 1);
  localparam logic [G_W-1:0] ALL  = {G_W{1'b1}};

  always_comb begin
    near = (mode == RM_NEAR);
    unique case (mode)
      RM_NEAR: inc = HALF;
      RM_UP:   inc = sign ? '0 : ALL;
      RM_DOWN: inc = sign ? ALL : '0;
      default: inc = '0;
    endcase
  end
endmodule

// File: rtl/sp_jam_shift.sv
module sp_jam_shift #(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  localparam int SW = $clog2(W);

  logic [W-1:0] st [SW+1];
  logic         huge;

  assign st[0] = din;
  assign huge  = |amt[AW-1:SW];

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign st[k+1] = amt[k] ? ((st[k] >> S) | W'(|st[k][S-1:0])) : st[k];
  end

  assign dout = huge ? W'(|din) : st[SW];

  always_comb begin
    // R7
    sticky_keep_chk: assert ((|din) == (|dout));
  end
endmodule

// File: rtl/sp_rounder.sv
module sp_rounder
  import sp_round_pack_pkg::*;
(
  input  logic              sign,
  input  logic [EF_W-1:0]   exp_f,
  input  logic [SIG_W-1:0]  sig,
  input  logic [GRD_W-1:0]  inc,
  input  logic              near,
  output logic [SIG_W-1:0]  word,
  output logic              guard_nz,
  output logic              up
);
  localparam logic [GRD_W-1:0] HALF = GRD_W'(1) << (GRD_W - 1);

  logic [GRD_W-1:0]  gbits;
  logic [RSIG_W-1:0] sig_r;
  logic [RSIG_W-1:0] sig_t;
  logic              tie;
  logic [EF_W-1:0]   exp_p;

  always_comb begin
    gbits    = sig[GRD_W-1:0];
    guard_nz = |gbits;
    sig_r    = RSIG_W'((sig + SIG_W'(inc)) >> GRD_W);
    tie      = near && (gbits == HALF);
    sig_t    = sig_r & ~RSIG_W'(tie);
    exp_p    = (sig_t == '0) ? '0 : exp_f;
    word     = {sign, {(SIG_W-1){1'b0}}}
             + {1'b0, exp_p, {FR_W{1'b0}}}
             + SIG_W'(sig_t);
    up       = guard_nz && ({sig_t, {GRD_W{1'b0}}} > sig);
  end

  always_comb begin
    // R9
    round_span_chk: assert (sig_t <= (RSIG_W'(1) << (RSIG_W - 1)));
  end
endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
  import sp_round_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic [1:0]        rnd_mode,
  input  logic              ovf_masked,
  input  logic              unf_masked,
  input  logic              flush_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SIG_W-1:0]  out_word,
  output logic              out_ovf,
  output logic              out_unf,
  output logic              out_inx,
  output logic              out_up
);
  localparam logic signed [EXP_W-1:0] OVF_E  = EXP_W'(OVF_EXP);
  localparam logic signed [EXP_W-1:0] BIAS_E = EXP_W'(BIAS_ADJ);
  localparam logic signed [EXP_W-1:0] NEG1_E = -16'sd1;
  localparam logic [SIG_W:0]          TOP_V  = (SIG_W+1)'(1) << (SIG_W - 1);

  logic [GRD_W-1:0]        inc;
  logic                    near;
  logic signed [EXP_W-1:0] e_in;
  logic signed [EXP_W-1:0] e_b;
  logic [EXP_W-1:0]        shamt;
  logic                    reach_top;
  logic                    hi_zone;
  logic                    ovf_hit;
  logic                    neg;
  logic                    tiny;
  logic                    bias_on;
  logic                    still_neg;
  logic                    flush_hit;
  logic [SIG_W-1:0]        sig_sh;
  logic [SIG_W-1:0]        sig_use;
  logic [EF_W-1:0]         exp_use;
  logic [SIG_W-1:0]        r_word;
  logic                    r_gnz;
  logic                    r_up;
  logic [SIG_W-1:0]        nxt_word;
  flags_t                  nxt_fl;
  flags_t                  fl_q;

  sp_incsel u_incsel (
    .mode (rnd_mode),
    .sign (in_sign),
    .inc  (inc),
    .near (near)
  );

  always_comb begin
    e_in      = in_exp;
    reach_top = ({1'b0, in_sig} + (SIG_W+1)'(inc)) >= TOP_V;
    hi_zone   = $unsigned(e_in) >= $unsigned(OVF_E);
    ovf_hit   = hi_zone && ((e_in > OVF_E) || ((e_in == OVF_E) && reach_top));
    neg       = e_in < 0;
    tiny      = neg && ((e_in < NEG1_E) || !reach_top);
    bias_on   = tiny && !unf_masked;
    e_b       = bias_on ? (e_in + BIAS_E) : e_in;
    still_neg = neg && (e_b < 0);
    shamt     = -e_b;
    flush_hit = still_neg && tiny && flush_en;
  end

  sp_jam_shift #(.W(SIG_W), .AW(EXP_W)) u_shift (
    .din  (in_sig),
    .amt  (shamt),
    .dout (sig_sh)
  );

  always_comb begin
    sig_use = still_neg ? sig_sh : in_sig;
    exp_use = still_neg ? '0 : e_b[EF_W-1:0];
  end

  sp_rounder u_round (
    .sign     (in_sign),
    .exp_f    (exp_use),
    .sig      (sig_use),
    .inc      (inc),
    .near     (near),
    .word     (r_word),
    .guard_nz (r_gnz),
    .up       (r_up)
  );

  always_comb begin
    nxt_fl = '0;
    if (ovf_hit) begin
      nxt_fl.ovf = 1'b1;
      nxt_fl.inx = (|in_sig[GRD_W-1:0]) || ovf_masked;
      nxt_fl.up  = nxt_fl.inx && (inc != '0);
      nxt_word   = (inc == '0) ? {in_sign, EF_W'(EXP_MAX - 1), {FR_W{1'b1}}}
                               : {in_sign, EF_W'(EXP_MAX), {FR_W{1'b0}}};
    end else if (flush_hit) begin
      nxt_fl.unf = 1'b1;
      nxt_fl.inx = 1'b1;
      nxt_word   = {in_sign, {(SIG_W-1){1'b0}}};
    end else begin
      nxt_fl.unf = bias_on || (still_neg && tiny && r_gnz);
      nxt_fl.inx = r_gnz;
      nxt_fl.up  = r_up;
      nxt_word   = r_word;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      fl_q      <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_word  <= nxt_word;
      fl_q      <= nxt_fl;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_ovf = fl_q.ovf;
  assign out_unf = fl_q.unf;
  assign out_inx = fl_q.inx;
  assign out_up  = fl_q.up;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(fl_q)));

  // R3
  ovf_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> ((out_word[SIG_W-2 -: EF_W] >= EF_W'(EXP_MAX - 1)) && !out_unf));

  // R4
  up_needs_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_up) |-> out_inx);
endmodule

// File: tb/tb_sp_round_pack.sv
module tb_sp_round_pack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [15:0] in_exp = '0;
  logic [31:0] in_sig = '0;
  logic [1:0]  rnd_mode = '0;
  logic        ovf_masked = 1'b0;
  logic        unf_masked = 1'b0;
  logic        flush_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_ovf, out_unf, out_inx, out_up;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sp_round_pack dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .rnd_mode(rnd_mode),
    .ovf_masked(ovf_masked), .unf_masked(unf_masked), .flush_en(flush_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx), .out_up(out_up)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // flags expected as {ovf, unf, inx, up}
  task automatic run_case(input string req, input logic s, input logic [15:0] e,
                          input logic [31:0] sig, input logic [1:0] m,
                          input logic um, input logic om, input logic fz,
                          input logic [31:0] ew, input logic [3:0] ef);
    @(negedge clk);
    in_sign = s; in_exp = e; in_sig = sig; rnd_mode = m;
    unf_masked = um; ovf_masked = om; flush_en = fz; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " word"}, out_word, ew);
    chk({req, " flags"}, 32'({out_ovf, out_unf, out_inx, out_up}), 32'(ef));
  endtask

  task automatic t_reset();
    chk("R11 out_valid", 32'(out_valid), 32'd0);
    chk("R11 in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_modes();
    run_case("R4 exact one",  0, 16'd126, 32'h4000_0000, 2'd0, 1, 0, 0, 32'h3F80_0000, 4'b0000);
    run_case("R1 near",       0, 16'd126, 32'h4000_0001, 2'd0, 1, 0, 0, 32'h3F80_0000, 4'b0010);
    run_case("R1 up pos",     0, 16'd126, 32'h4000_0001, 2'd2, 1, 0, 0, 32'h3F80_0001, 4'b0011);
    run_case("R1 down pos",   0, 16'd126, 32'h4000_0001, 2'd1, 1, 0, 0, 32'h3F80_0000, 4'b0010);
    run_case("R1 zero",       0, 16'd126, 32'h4000_0001, 2'd3, 1, 0, 0, 32'h3F80_0000, 4'b0010);
    run_case("R1 down neg",   1, 16'd126, 32'h4000_0001, 2'd1, 1, 0, 0, 32'hBF80_0001, 4'b0011);
    run_case("R1 up neg",     1, 16'd126, 32'h4000_0001, 2'd2, 1, 0, 0, 32'hBF80_0000, 4'b0010);
  endtask

  task automatic t_ties();
    run_case("R2 tie even",   0, 16'd126, 32'h4000_0040, 2'd0, 1, 0, 0, 32'h3F80_0000, 4'b0010);
    run_case("R2 tie odd",    0, 16'd126, 32'h4000_00C0, 2'd0, 1, 0, 0, 32'h3F80_0002, 4'b0011);
    run_case("R2 above half", 0, 16'd126, 32'h4000_0041, 2'd0, 1, 0, 0, 32'h3F80_0001, 4'b0011);
    run_case("R9 carry",      0, 16'd126, 32'h7FFF_FFC0, 2'd0, 1, 0, 0, 32'h4000_0000, 4'b0011);
  endtask

  task automatic t_overflow();
    run_case("R3 inf masked", 0, 16'h00FE, 32'h4000_0000, 2'd0, 1, 1, 0, 32'h7F80_0000, 4'b1011);
    run_case("R3 max zero",   0, 16'h00FE, 32'h4000_0000, 2'd3, 1, 0, 0, 32'h7F7F_FFFF, 4'b1000);
    run_case("R3 edge carry", 0, 16'h00FD, 32'h7FFF_FFC0, 2'd0, 1, 0, 0, 32'h7F80_0000, 4'b1011);
    run_case("R3 edge no ov", 0, 16'h00FD, 32'h7FFF_FFC0, 2'd3, 1, 0, 0, 32'h7F7F_FFFF, 4'b0010);
    run_case("R3 neg inf",    1, 16'h0100, 32'h4000_0000, 2'd1, 1, 0, 0, 32'hFF80_0000, 4'b1000);
    run_case("R3 neg max",    1, 16'h0100, 32'h4000_0000, 2'd2, 1, 0, 0, 32'hFF7F_FFFF, 4'b1000);
  endtask

  task automatic t_underflow();
    run_case("R6 bias",       0, -16'sd2,   32'h4000_0000, 2'd0, 0, 0, 0, 32'h5F80_0000, 4'b0100);
    run_case("R6 bias shift", 0, -16'sd200, 32'h4000_0000, 2'd0, 0, 0, 0, 32'h0000_8000, 4'b0100);
    run_case("R7 exact",      0, -16'sd2,   32'h4000_0000, 2'd0, 1, 0, 0, 32'h0020_0000, 4'b0000);
    run_case("R7 sticky",     0, -16'sd2,   32'h4000_0001, 2'd0, 1, 0, 0, 32'h0020_0000, 4'b0110);
    run_case("R7 huge near",  0, -16'sd200, 32'h4000_0000, 2'd0, 1, 0, 0, 32'h0000_0000, 4'b0110);
    run_case("R7 huge down",  1, -16'sd200, 32'h4000_0000, 2'd1, 1, 0, 0, 32'h8000_0001, 4'b0111);
    run_case("R5 not tiny",   0, -16'sd1,   32'h7FFF_FFC0, 2'd0, 1, 0, 0, 32'h0080_0000, 4'b0011);
    run_case("R5 not tiny um",0, -16'sd1,   32'h7FFF_FFC0, 2'd0, 0, 0, 0, 32'h0080_0000, 4'b0011);
    run_case("R5 tiny zero",  0, -16'sd1,   32'h7FFF_FFC0, 2'd3, 1, 0, 0, 32'h007F_FFFF, 4'b0110);
  endtask

  task automatic t_flush();
    run_case("R8 flush",      1, -16'sd2,   32'h4000_0000, 2'd0, 1, 0, 1, 32'h8000_0000, 4'b0110);
    run_case("R8 no tiny",    0, -16'sd1,   32'h7FFF_FFC0, 2'd0, 1, 0, 1, 32'h0080_0000, 4'b0011);
    run_case("R8 unmasked",   0, -16'sd2,   32'h4000_0000, 2'd0, 0, 0, 1, 32'h5F80_0000, 4'b0100);
  endtask

  task automatic t_zero();
    run_case("R9 zero pos",   0, 16'h0040, 32'h0000_0000, 2'd0, 1, 0, 0, 32'h0000_0000, 4'b0000);
    run_case("R9 zero neg",   1, 16'h0040, 32'h0000_0000, 2'd0, 1, 0, 0, 32'h8000_0000, 4'b0000);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    in_sign = 0; in_exp = 16'd126; in_sig = 32'h4000_0000; rnd_mode = 2'd0;
    unf_masked = 1; ovf_masked = 0; flush_en = 0; in_valid = 1'b1;
    @(negedge clk);
    in_sig = 32'h4000_0001; rnd_mode = 2'd2;
    for (int i = 0; i < 3; i++) begin
      chk("R10 stall valid", 32'(out_valid), 32'd1);
      chk("R10 stall ready", 32'(in_ready), 32'd0);
      chk("R10 stall word", out_word, 32'h3F80_0000);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next word", out_word, 32'h3F80_0001);
    chk("R10 next flags", 32'({out_ovf, out_unf, out_inx, out_up}), 32'b0011);
    @(negedge clk);
    chk("R10 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_ties();
    t_overflow();
    t_underflow();
    t_flush();
    t_zero();
    t_stall();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule